// File: doc/BRIEF.md
# ADC Result Register and Conversion Flag Block

This block stands between a multi-channel analog-to-digital converter core and a register read path. Every time the converter finishes a conversion it presents a one-cycle pulse carrying the channel index and the 10-bit result. The block stores that result in the register for that channel. It also copies the result, together with the channel index, into one shared "most recent result" register.

For each channel the block keeps a conversion-complete flag and a data-lost flag. Two more flags cover all channels: a result-pending flag and a lost-result flag. Reading a channel register clears that channel's conversion-complete flag. Reading the shared register clears the result-pending flag. Reading the status word clears all data-lost flags and the lost-result flag. None of these clears touches any other flag.

The flags are presented as one 32-bit status word. The read path sees the register values combinationally during the read cycle. Any clear caused by the read takes effect at the clock edge that ends that cycle.

Top module: `adc_result_flags`

## Requirements
- R1: When a conversion for channel i (i < 6) is accepted, channel register i holds its 10-bit result from the next cycle on. The register keeps that value until the next conversion of channel i.
- R2: The conversion-complete flag of channel i is set by a conversion of channel i. It is cleared by a channel read strobe whose select equals i.
- R3: Every accepted conversion loads the shared register with the result and with the 3-bit channel index.
- R4: The result-pending flag is set by any accepted conversion. It is cleared by a read strobe of the shared register.
- R5: The data-lost flag of channel i is set when a conversion of channel i arrives while the conversion-complete flag of channel i is already 1.
- R6: The lost-result flag is set when a conversion arrives while the result-pending flag is already 1.
- R7: A status read strobe clears every data-lost flag and the lost-result flag. It leaves the conversion-complete flags and the result-pending flag unchanged.
- R8: When a set condition and a clear condition of the same flag occur in the same cycle, the flag ends up set.
- R9: The status word carries the conversion-complete flags of channels 5..0 in bits 5:0 and the data-lost flags of channels 5..0 in bits 13:8. Bit 16 is the result-pending flag and bit 17 is the lost-result flag. All other bits read 0. During a status read, the word shows the flag values from before that read's clears.
- R10: A conversion pulse whose channel index is 6 or 7 changes no register and no flag.
- R11: While rst_n is low at a rising clock edge, all data registers, the stored channel index and all flags become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| conv_valid | input | 1 | One-cycle conversion-complete pulse |
| conv_chan | input | 3 | Channel index of the finished conversion |
| conv_data | input | 10 | Conversion result |
| rd_chan_stb | input | 1 | Read strobe for a channel register |
| rd_chan_sel | input | 3 | Channel register selected for reading |
| rd_last_stb | input | 1 | Read strobe for the shared register |
| rd_status_stb | input | 1 | Read strobe for the status word |
| chan_data | output | 10 | Selected channel register (0 when the select is out of range) |
| last_data | output | 10 | Most recent result |
| last_chan | output | 3 | Channel index of the most recent result |
| status_word | output | 32 | Packed flags |

## Verification
The bench goes after collisions between flag set and flag clear. A conversion that lands in the same cycle as a read of its own channel must leave the flag set (R8). A design that lets the clear win would report no pending data even though a fresh result is waiting. The bench also checks that a status read clears only the loss flags. A design whose status read also cleared the completion flags would lose track of unread results. Conversions for channel indexes 6 and 7 must be ignored, because an index decode that wraps or aliases would corrupt a real channel. A long mixed sequence then compares every flag and register each cycle against a bench model, including the pre-clear status value seen during a status read.

// File: rtl/adc_res_pkg.sv
// Package: shared layout constants for the ADC result block.
// Assumes at most 8 channels so each flag group fits its byte lane.
package adc_res_pkg;
    localparam int STAT_W    = 32;
    localparam int EOC_LSB   = 0;
    localparam int OVRE_LSB  = 8;
    localparam int DRDY_BIT  = 16;
    localparam int GOVRE_BIT = 17;
endpackage

// File: rtl/adc_chan_slot.sv
// Module: one channel's result register plus its completion and loss flags.
// Assumes load is already qualified by channel decode; set beats clear.
module adc_chan_slot #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              rd_clr,
    input  logic              stat_clr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              done_flag,
    output logic              lost_flag
);
    // Purpose: capture the channel result on load.
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

    // Purpose: completion flag, set by load, cleared by channel read.
    always_ff @(posedge clk) begin
        if (!rst_n) done_flag <= 1'b0;
        else        done_flag <= load | (done_flag & ~rd_clr);
    end

    // Purpose: loss flag, set by load onto an unread result, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n) lost_flag <= 1'b0;
        else        lost_flag <= (load & done_flag) | (lost_flag & ~stat_clr);
    end

    assert_load_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> dout == $past(din));
    assert_done_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> done_flag);
    assert_done_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !load) |=> !done_flag);
    assert_lost_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && done_flag) |=> lost_flag);
    assert_lost_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !(load && done_flag)) |=> !lost_flag);
    assert_done_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !rd_clr && done_flag) |=> done_flag);
endmodule

// File: rtl/adc_last_reg.sv
// Module: shared most-recent-result register with pending and lost-result flags.
// Assumes load pulses once per accepted conversion; set beats clear.
module adc_last_reg #(
    parameter int DATA_W = 10,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CH_W-1:0]   chan_in,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_clr,
    input  logic              stat_clr,
    output logic [DATA_W-1:0] last_data,
    output logic [CH_W-1:0]   last_chan,
    output logic              pend_flag,
    output logic              glost_flag
);
    // Purpose: record result and source channel on every accepted conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_data <= '0;
            last_chan <= '0;
        end else if (load) begin
            last_data <= din;
            last_chan <= chan_in;
        end
    end

    // Purpose: pending flag, set by any conversion, cleared by shared-register read.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_flag <= 1'b0;
        else        pend_flag <= load | (pend_flag & ~rd_clr);
    end

    // Purpose: lost-result flag, set when pending data is overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n) glost_flag <= 1'b0;
        else        glost_flag <= (load & pend_flag) | (glost_flag & ~stat_clr);
    end

    assert_last_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (last_data == $past(din)) && (last_chan == $past(chan_in)));
    assert_pend_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pend_flag);
    assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !load) |=> !pend_flag);
    assert_glost_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && pend_flag) |=> glost_flag);
    assert_glost_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !(load && pend_flag)) |=> !glost_flag);
endmodule

// File: rtl/adc_result_flags.sv
// Module: top of the ADC result block. Decodes the conversion channel,
// keeps one slot per channel plus the shared register, and packs the status.
// Assumes CH_NUM <= 8; out-of-range conversion channels are ignored.
module adc_result_flags #(
    parameter int CH_NUM = 6,
    parameter int DATA_W = 10,
    parameter int CH_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          conv_valid,
    input  logic [CH_W-1:0]               conv_chan,
    input  logic [DATA_W-1:0]             conv_data,
    input  logic                          rd_chan_stb,
    input  logic [CH_W-1:0]               rd_chan_sel,
    input  logic                          rd_last_stb,
    input  logic                          rd_status_stb,
    output logic [DATA_W-1:0]             chan_data,
    output logic [DATA_W-1:0]             last_data,
    output logic [CH_W-1:0]               last_chan,
    output logic [adc_res_pkg::STAT_W-1:0] status_word
);
    import adc_res_pkg::*;

    logic              conv_ok;
    logic [CH_NUM-1:0] done_vec;
    logic [CH_NUM-1:0] lost_vec;
    logic [DATA_W-1:0] slot_data [CH_NUM];
    logic              pend_flag;
    logic              glost_flag;

    // Purpose: accept a conversion only for an existing channel.
    always_comb conv_ok = conv_valid && (int'(conv_chan) < CH_NUM);

    for (genvar i = 0; i < CH_NUM; i++) begin : g_slot
        adc_chan_slot #(.DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (conv_ok && (conv_chan == CH_W'(i))),
            .rd_clr    (rd_chan_stb && (rd_chan_sel == CH_W'(i))),
            .stat_clr  (rd_status_stb),
            .din       (conv_data),
            .dout      (slot_data[i]),
            .done_flag (done_vec[i]),
            .lost_flag (lost_vec[i])
        );
    end

    adc_last_reg #(.DATA_W(DATA_W), .CH_W(CH_W)) u_last (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (conv_ok),
        .chan_in    (conv_chan),
        .din        (conv_data),
        .rd_clr     (rd_last_stb),
        .stat_clr   (rd_status_stb),
        .last_data  (last_data),
        .last_chan  (last_chan),
        .pend_flag  (pend_flag),
        .glost_flag (glost_flag)
    );

    // Purpose: route the selected channel register to the read port.
    always_comb begin
        chan_data = '0;
        for (int i = 0; i < CH_NUM; i++)
            if (rd_chan_sel == CH_W'(i)) chan_data = slot_data[i];
    end

    // Purpose: pack the current flags into the status word.
    always_comb begin
        status_word = '0;
        status_word[EOC_LSB  +: CH_NUM] = done_vec;
        status_word[OVRE_LSB +: CH_NUM] = lost_vec;
        status_word[DRDY_BIT]           = pend_flag;
        status_word[GOVRE_BIT]          = glost_flag;
    end

    assert_bad_chan_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && int'(conv_chan) >= CH_NUM && !rd_chan_stb && !rd_last_stb
         && !rd_status_stb) |=> $stable(status_word) && $stable(last_data)
         && $stable(last_chan));
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_ok && rd_last_stb) |=> status_word[DRDY_BIT]);
endmodule

// File: tb/adc_result_flags_bench.sv
`timescale 1ns/100ps
module adc_result_flags_bench;
    localparam int NCH = 6;
    localparam int DW  = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_valid = 1'b0;
    logic [2:0]    conv_chan = '0;
    logic [DW-1:0] conv_data = '0;
    logic          rd_chan_stb = 1'b0;
    logic [2:0]    rd_chan_sel = '0;
    logic          rd_last_stb = 1'b0;
    logic          rd_status_stb = 1'b0;
    logic [DW-1:0] chan_data;
    logic [DW-1:0] last_data;
    logic [2:0]    last_chan;
    logic [31:0]   status_word;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model
    logic [DW-1:0] m_data [NCH];
    logic [NCH-1:0] m_done, m_lost;
    logic m_pend, m_glost;
    logic [DW-1:0] m_last;
    logic [2:0] m_lchan;

    always #2 clk = ~clk;

    adc_result_flags u_adc_result_flags (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_chan(conv_chan),
        .conv_data(conv_data), .rd_chan_stb(rd_chan_stb), .rd_chan_sel(rd_chan_sel),
        .rd_last_stb(rd_last_stb), .rd_status_stb(rd_status_stb),
        .chan_data(chan_data), .last_data(last_data), .last_chan(last_chan),
        .status_word(status_word)
    );

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[5:0]   = m_done;
        s[13:8]  = m_lost;
        s[16]    = m_pend;
        s[17]    = m_glost;
        return s;
    endfunction

    task automatic chk(string req, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): actual=%h expected=%h", req, tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) m_data[i] = '0;
        m_done = '0; m_lost = '0; m_pend = 0; m_glost = 0; m_last = '0; m_lchan = '0;
    endtask

    // compare every observable field against the model
    task automatic check_all(string tag);
        chk("R2", tag, 32'(status_word[5:0]), 32'(m_done));
        chk("R5", tag, 32'(status_word[13:8]), 32'(m_lost));
        chk("R4", tag, 32'(status_word[16]), 32'(m_pend));
        chk("R6", tag, 32'(status_word[17]), 32'(m_glost));
        chk("R9", tag, {status_word[31:18], status_word[15:14], status_word[7:6]}, 32'd0);
        chk("R3", tag, {19'd0, last_chan, last_data}, {19'd0, m_lchan, m_last});
        for (int i = 0; i < 8; i++) begin
            rd_chan_sel = 3'(i);
            #0.1;
            chk("R1", tag, 32'(chan_data), (i < NCH) ? 32'(m_data[i]) : 32'd0);
        end
    endtask

    task automatic step(bit cv, int ch, int d, bit rs, int sel, bit rl, bit rst, string tag);
        logic hit;
        @(negedge clk);
        conv_valid = cv; conv_chan = 3'(ch); conv_data = DW'(d);
        rd_chan_stb = rs; rd_chan_sel = 3'(sel); rd_last_stb = rl; rd_status_stb = rst;
        #1;
        if (rst) chk("R9", {tag, " pre-clear"}, status_word, exp_status());
        if (rs)  chk("R1", {tag, " read"}, 32'(chan_data), (sel < NCH) ? 32'(m_data[sel]) : 32'd0);
        @(posedge clk);
        hit = cv && (ch < NCH);
        if (!rst_n) model_reset();
        else begin
            for (int i = 0; i < NCH; i++) begin
                logic h = hit && (ch == i);
                m_lost[i] = (h && m_done[i]) || (m_lost[i] && !rst);
                m_done[i] = h || (m_done[i] && !(rs && sel == i));
                if (h) m_data[i] = DW'(d);
            end
            m_glost = (hit && m_pend) || (m_glost && !rst);
            m_pend  = hit || (m_pend && !rl);
            if (hit) begin m_last = DW'(d); m_lchan = 3'(ch); end
        end
        #1;
        conv_valid = 0; rd_chan_stb = 0; rd_last_stb = 0; rd_status_stb = 0;
        check_all(tag);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        int pat [4] = '{0, 1023, 'h2AA, 'h155};
        model_reset();
        // R11: reset state
        step(1, 2, 77, 0, 0, 0, 0, "R11 reset");
        step(0, 0, 0, 0, 0, 0, 0, "R11 reset");
        rst_n = 1'b1;
        // R1 R2 R3 R4: every channel, several data patterns, then reads
        for (int c = 0; c < NCH; c++)
            for (int p = 0; p < 4; p++) begin
                step(1, c, pat[p] ^ (c * 97), 0, 0, 0, 0, "R1 load");
                step(0, 0, 0, 1, c, 0, 0, "R2 chan read");
                step(0, 0, 0, 0, 0, 1, 0, "R4 last read");
            end
        // R5 R6 R7: double conversion per channel, then status read
        for (int c = 0; c < NCH; c++) begin
            step(1, c, 100 + c, 0, 0, 0, 0, "R5 first");
            step(1, c, 200 + c, 0, 0, 0, 0, "R5 R6 second");
            step(0, 0, 0, 0, 0, 0, 1, "R7 status clear");
            step(0, 0, 0, 1, c, 1, 0, "R7 drain");
        end
        // R8: set and clear collide
        for (int c = 0; c < NCH; c++) begin
            step(1, c, 300 + c, 1, c, 1, 0, "R8 eoc/drdy");
            step(1, c, 400 + c, 0, 0, 0, 1, "R8 ovre/govre");
            step(0, 0, 0, 0, 0, 0, 1, "R8 cleanup");
            step(0, 0, 0, 1, c, 1, 0, "R8 cleanup");
        end
        // R10: channel indexes beyond the last channel
        step(1, 3, 555, 0, 0, 0, 0, "R10 setup");
        for (int c = NCH; c < 8; c++)
            for (int p = 0; p < 4; p++)
                step(1, c, pat[p], 0, 0, 0, 0, "R10 ignored");
        // mixed sequence against the model
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom);
            step(r[0], r[4:2], r[14:5], r[15] & r[16], r[19:17], r[20] & r[21],
                 r[22] & r[23] & r[24], "R1 R5 R9 mix");
        end
        // R11: reset after activity
        rst_n = 1'b0;
        step(1, 1, 9, 1, 1, 0, 0, "R11 mid reset");
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, "R11 after reset");
        report();
    end
endmodule